// File: doc/BRIEF.md
# Pseudo-Static RAM Host Controller

This block connects a single requester on a simple request/acknowledge bus to a 32K x 16 pseudo-static RAM that has separate lower and upper byte strobes. The requester raises `req` with a word address, write data, a write flag and two byte enables. It holds them until `ack` pulses for one cycle. For a read, `rdata` is valid in that same cycle. The controller produces every memory-side strobe from registered state. Each phase length is a cycle count, given as a parameter and rounded up from a nanosecond limit for the chosen clock period.

After reset the controller keeps the memory idle for a long power-up wait. It then runs a fixed number of chip-enable-only dummy cycles and only after that raises `init_done` and serves requests. From then on, a free-running timer asks for one auto refresh per interval. The refresh uses the lower output-enable pin while chip enable is high. A pending refresh is served before a waiting request but never cuts short an access that has begun.

The memory data bus is split into an input, an output and an output-enable, so that the pad ring can build the bidirectional pins.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is held, `mem_ce_n`, `mem_oe_lo_n`, `mem_oe_hi_n`, `mem_we_lo_n` and `mem_we_hi_n` are 1, and `mem_dq_oe`, `ack` and `init_done` are 0.
- R2: After reset, chip enable stays high for at least `T_PWR` cycles. Then exactly `N_DUMMY` chip-enable pulses occur before `init_done` becomes 1.
- R3: Before `init_done` no write strobe or upper output enable goes low and no `ack` is given. A request held during initialisation is served once `init_done` is 1.
- R4: Every chip-enable pulse lasts exactly `ACC_CYC` cycles (4 at the defaults). During a read both output enables are low, and `rdata` takes the bus value present at the end of the pulse.
- R5: `req_be[0]` enables the lower write strobe, which covers data bits 7:0. `req_be[1]` enables the upper write strobe, which covers bits 15:8. A disabled byte keeps its stored value.
- R6: `mem_dq_oe` is 1 only while chip enable is low and at least one write strobe is low.
- R7: Between two chip-enable pulses, chip enable stays high for at least `T_PRE` cycles.
- R8: `ack` is a one-cycle pulse. A request seen by an idle controller is acknowledged `ACC_CYC`+1 cycles after it is first driven, sampled mid-cycle.
- R9: A refresh drives `mem_oe_lo_n` low with chip enable high for exactly `T_FAP` cycles. It starts at least `T_RFD` cycles after chip enable rises. Chip enable falls again no sooner than `T_FCE` cycles after the refresh starts.
- R10: A pending refresh wins over a waiting request, so refreshes continue under back-to-back requests. A request that arrives during a refresh waits for it to end.
- R11: Once initialised and without any traffic, the controller issues one refresh per `REF_INTERVAL` cycles.
- R12: Chip enable never stays low for more than `T_CE_MAX` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request, held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | 2 | Byte enables: bit 0 lower byte, bit 1 upper byte |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read data, valid with `ack` |
| init_done | output | 1 | Power-up sequence finished |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_lo_n | output | 1 | Lower output enable, also the refresh strobe while chip enable is high |
| mem_oe_hi_n | output | 1 | Upper output enable |
| mem_we_lo_n | output | 1 | Lower byte write strobe |
| mem_we_hi_n | output | 1 | Upper byte write strobe |
| mem_addr | output | ADDR_W | Memory address, held from accept to next accept |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Data from the memory |

## Verification
A request driven at a falling clock edge is taken at the next rising edge. Chip enable then falls, and `ack` and `rdata` appear after the `ACC_CYC`-th following rising edge. The bench therefore expects them on its fifth mid-cycle sample and reads `rdata` in that same sample. The memory model in the bench returns data only from the fourth mid-cycle sample of a chip-enable pulse onward, so any capture a cycle early shows up as wrong data. All pin-level timing rules (pulse widths, precharge, refresh spacing) are measured by a monitor that samples at every falling clock edge. They are compared with cycle counts derived in the bench from the nanosecond limits at a 20 ns period.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PWR   = 3'd0,  // power-up wait, memory idle
    ST_DUMMY = 3'd1,  // init dummy cycle, chip enable low
    ST_DPRE  = 3'd2,  // init dummy precharge
    ST_IDLE  = 3'd3,
    ST_ACC   = 3'd4,  // host access, chip enable low
    ST_PRE   = 3'd5,  // precharge after host access
    ST_RLOW  = 3'd6,  // refresh strobe low
    ST_RHOLD = 3'd7   // refresh recovery
  } ctrl_state_e;

  // round a nanosecond limit up to whole clock cycles
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_wait_cnt.sv
module psram_wait_cnt #(
  parameter int W       = 8,
  parameter int RST_LEN = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         done
);

  logic [W-1:0] cnt;

  // a phase of length len stays in its state for len cycles
  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= W'(RST_LEN - 1);
    else if (load)         cnt <= len - W'(1);
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/psram_ref_timer.sv
module psram_ref_timer #(
  parameter int PERIOD = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic grant,
  output logic tick,
  output logic pending
);

  localparam int TW = $clog2(PERIOD + 1);

  logic [TW-1:0] cnt;

  assign tick = en && (cnt == TW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      if (!en || tick) cnt <= '0;
      else             cnt <= cnt + TW'(1);
      if (tick)        pending <= 1'b1;
      else if (grant)  pending <= 1'b0;
    end
  end

endmodule

// File: rtl/psram_pin_decode.sv
module psram_pin_decode (
  input  psram_ctrl_pkg::ctrl_state_e state,
  input  logic                        we,
  input  logic [1:0]                  be,
  output logic                        ce_n,
  output logic                        oe_lo_n,
  output logic                        oe_hi_n,
  output logic                        we_lo_n,
  output logic                        we_hi_n,
  output logic                        dq_oe
);
  import psram_ctrl_pkg::*;

  logic in_acc, rd_phase, wr_phase;

  always_comb begin
    in_acc   = (state == ST_ACC);
    rd_phase = in_acc && !we;
    wr_phase = in_acc && we;
    ce_n     = !(in_acc || state == ST_DUMMY);
    oe_lo_n  = !(rd_phase || state == ST_RLOW);
    oe_hi_n  = !rd_phase;
    we_lo_n  = !(wr_phase && be[0]);
    we_hi_n  = !(wr_phase && be[1]);
    dq_oe    = wr_phase && (be != 2'b00);
  end

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 16,
  parameter int CLK_NS       = 20,
  parameter int T_CE         = ns_to_cyc(80, CLK_NS),
  parameter int T_WP         = ns_to_cyc(60, CLK_NS),
  parameter int T_PRE        = ns_to_cyc(50, CLK_NS),
  parameter int T_RC         = ns_to_cyc(140, CLK_NS),
  parameter int T_RFD        = ns_to_cyc(50, CLK_NS),
  parameter int T_FAP        = ns_to_cyc(30, CLK_NS),
  parameter int T_FCE        = ns_to_cyc(160, CLK_NS),
  parameter int T_FC         = ns_to_cyc(140, CLK_NS),
  parameter int T_CE_MAX     = ns_to_cyc(10000, CLK_NS),
  parameter int T_PWR        = ns_to_cyc(200000, CLK_NS),
  parameter int N_DUMMY      = 8,
  parameter int REF_INTERVAL = ns_to_cyc(15600, CLK_NS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              init_done,
  output logic              mem_ce_n,
  output logic              mem_oe_lo_n,
  output logic              mem_oe_hi_n,
  output logic              mem_we_lo_n,
  output logic              mem_we_hi_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  // phase lengths in cycles
  localparam int ACC_CYC   = max2(T_CE, T_WP);
  localparam int PRE_CYC   = max2(max2(T_PRE, T_RFD), T_RC - ACC_CYC);
  localparam int RLOW_CYC  = T_FAP;
  localparam int RHOLD_CYC = max2(max2(T_FCE, T_FC) - T_FAP, 1);
  localparam int MAX_LEN   = max2(max2(T_PWR, ACC_CYC),
                                  max2(PRE_CYC, max2(RLOW_CYC, RHOLD_CYC)));
  localparam int CNT_W     = $clog2(MAX_LEN + 1);
  localparam int DUM_W     = $clog2(N_DUMMY + 1);

  ctrl_state_e       state, state_d;
  logic [CNT_W-1:0]  wlen;
  logic              wload, wdone;
  logic [DUM_W-1:0]  dummy_left;
  logic              last_dummy;
  logic              cmd_we;
  logic [1:0]        cmd_be;

  // named internal events
  logic ref_tick, ref_pend, rf_grant, acc_start, acc_end;

  assign last_dummy = (dummy_left == DUM_W'(1));
  assign rf_grant   = (state == ST_IDLE) && ref_pend;
  assign acc_start  = (state == ST_IDLE) && !ref_pend && req;
  assign acc_end    = (state == ST_ACC) && wdone;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_PWR:   if (wdone) state_d = ST_DUMMY;
      ST_DUMMY: if (wdone) state_d = ST_DPRE;
      ST_DPRE:  if (wdone) state_d = last_dummy ? ST_IDLE : ST_DUMMY;
      ST_IDLE:  if (ref_pend)  state_d = ST_RLOW;
                else if (req)  state_d = ST_ACC;
      ST_ACC:   if (wdone) state_d = ST_PRE;
      ST_PRE:   if (wdone) state_d = ST_IDLE;
      ST_RLOW:  if (wdone) state_d = ST_RHOLD;
      ST_RHOLD: if (wdone) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    wload = (state_d != state);
    unique case (state_d)
      ST_DUMMY, ST_ACC: wlen = CNT_W'(ACC_CYC);
      ST_DPRE,  ST_PRE: wlen = CNT_W'(PRE_CYC);
      ST_RLOW:          wlen = CNT_W'(RLOW_CYC);
      ST_RHOLD:         wlen = CNT_W'(RHOLD_CYC);
      default:          wlen = CNT_W'(1);
    endcase
  end

  psram_wait_cnt #(
    .W       (CNT_W),
    .RST_LEN (T_PWR)
  ) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wload),
    .len   (wlen),
    .done  (wdone)
  );

  psram_ref_timer #(
    .PERIOD (REF_INTERVAL)
  ) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (init_done),
    .grant   (rf_grant),
    .tick    (ref_tick),
    .pending (ref_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_PWR;
      dummy_left <= DUM_W'(N_DUMMY);
      init_done  <= 1'b0;
      ack        <= 1'b0;
      rdata      <= '0;
      cmd_we     <= 1'b0;
      cmd_be     <= 2'b00;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else begin
      state <= state_d;
      ack   <= acc_end;
      if (acc_end && !cmd_we) rdata <= mem_dq_in;
      if (acc_start) begin
        cmd_we     <= req_we;
        cmd_be     <= req_be;
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (state == ST_DPRE && wdone) begin
        dummy_left <= dummy_left - DUM_W'(1);
        if (last_dummy) init_done <= 1'b1;
      end
    end
  end

  psram_pin_decode u_pins (
    .state   (state),
    .we      (cmd_we),
    .be      (cmd_be),
    .ce_n    (mem_ce_n),
    .oe_lo_n (mem_oe_lo_n),
    .oe_hi_n (mem_oe_hi_n),
    .we_lo_n (mem_we_lo_n),
    .we_hi_n (mem_we_hi_n),
    .dq_oe   (mem_dq_oe)
  );

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
  parameter int ACC_CYC = 4,
  parameter int PRE_MIN = 3,
  parameter int RFD_MIN = 3,
  parameter int FAP_CYC = 2,
  parameter int FCE_MIN = 8,
  parameter int CE_MAX  = 500
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_lo_n,
  input logic oe_hi_n,
  input logic we_lo_n,
  input logic we_hi_n,
  input logic dq_oe,
  input logic ack,
  input logic init_done,
  input logic ref_tick,
  input logic ref_pend
);

  logic        ce_lo, rf_act;
  logic [15:0] lo_run, hi_run, rf_run, since_rf;

  assign ce_lo  = !ce_n;
  assign rf_act = ce_n && !oe_lo_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run   <= '0;
      hi_run   <= '0;
      rf_run   <= '0;
      since_rf <= 16'hFFFF;
    end else begin
      lo_run <= ce_lo ? lo_run + 16'd1 : 16'd0;
      if (ce_lo)                  hi_run <= '0;
      else if (hi_run != 16'hFFFF) hi_run <= hi_run + 16'd1;
      rf_run <= rf_act ? rf_run + 16'd1 : 16'd0;
      if (rf_act && rf_run == 16'd0)  since_rf <= 16'd1;
      else if (since_rf != 16'hFFFF)  since_rf <= since_rf + 16'd1;
    end
  end

  a_r4_ce_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_lo) |-> lo_run == 16'(ACC_CYC));

  a_r12_ce_max: assert property (@(posedge clk) disable iff (!rst_n)
    lo_run <= 16'(CE_MAX));

  a_r7_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_lo) |-> hi_run >= 16'(PRE_MIN));

  a_r9_rfsh_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rf_act) |-> rf_run == 16'(FAP_CYC));

  a_r9_rfsh_after_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rf_act) |-> hi_run >= 16'(RFD_MIN));

  a_r9_ce_after_rfsh: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_lo) |-> since_rf >= 16'(FCE_MIN));

  a_r6_dq_drive: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (ce_lo && (!we_lo_n || !we_hi_n)));

  a_r3_quiet_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (we_lo_n && we_hi_n && oe_hi_n && !ack));

  a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r10_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ce_lo) && init_done) |-> !$past(ref_pend));

  a_r11_tick_pends: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> ref_pend);

endmodule

bind psram_ctrl psram_ctrl_chk #(
  .ACC_CYC (ACC_CYC),
  .PRE_MIN (T_PRE),
  .RFD_MIN (T_RFD),
  .FAP_CYC (T_FAP),
  .FCE_MIN (T_FCE),
  .CE_MAX  (T_CE_MAX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (mem_ce_n),
  .oe_lo_n   (mem_oe_lo_n),
  .oe_hi_n   (mem_oe_hi_n),
  .we_lo_n   (mem_we_lo_n),
  .we_hi_n   (mem_we_hi_n),
  .dq_oe     (mem_dq_oe),
  .ack       (ack),
  .init_done (init_done),
  .ref_tick  (ref_tick),
  .ref_pend  (ref_pend)
);

// File: tb/psram_ctrl_test.sv
module psram_ctrl_test;

  // cycle counts at a 20 ns clock, rounded up from the ns limits
  localparam int ACC  = 4;    // 80 ns
  localparam int PRE  = 3;    // 50 ns
  localparam int RFD  = 3;    // 50 ns
  localparam int FAP  = 2;    // 30 ns
  localparam int FCE  = 8;    // 160 ns
  localparam int CEMX = 500;  // 10 us
  localparam int PWR  = 40;   // shortened for the bench
  localparam int NDUM = 8;
  localparam int RINT = 100;  // shortened for the bench

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b00;
  logic        ack, init_done;
  logic [15:0] rdata;
  logic        mem_ce_n, mem_oe_lo_n, mem_oe_hi_n, mem_we_lo_n, mem_we_hi_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [15:0] mem_dq_out, mem_dq_in;

  always #10 clk = ~clk;

  psram_ctrl #(.T_PWR(PWR), .REF_INTERVAL(RINT)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rdata(rdata),
    .init_done(init_done), .mem_ce_n(mem_ce_n), .mem_oe_lo_n(mem_oe_lo_n),
    .mem_oe_hi_n(mem_oe_hi_n), .mem_we_lo_n(mem_we_lo_n), .mem_we_hi_n(mem_we_hi_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0, n_err = 0;
  int rel_cyc = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic chk_ge(input string rq, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", rq, act, lo, hi);
    end
  endtask

  // ---------------- memory model and pin monitor ----------------
  logic [15:0] mem [0:255];
  logic [7:0]  lat_a = '0;
  int ce_cnt = 0, lo_run = 0, hi_run = 0, rf_run = 0, since_rf = 100000;
  int n_ce_fall = 0, n_rf = 0, first_fall = -1, falls_at_init = -1, cyc_at_init = -1;
  int v_ce = 0, v_pre = 0, v_rfd = 0, v_fap = 0, v_fce = 0, v_dq = 0, v_init = 0, v_oe = 0, v_max = 0;
  logic p_ce_n = 1'b1, p_rf = 1'b0;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101);

  assign mem_dq_in = { (!mem_ce_n && ce_cnt >= ACC && !mem_oe_hi_n) ? mem[lat_a][15:8] : 8'hDE,
                       (!mem_ce_n && ce_cnt >= ACC && !mem_oe_lo_n) ? mem[lat_a][7:0]  : 8'hAD };

  always @(posedge clk) if (rst_n) rel_cyc++;

  always @(negedge clk) begin
    logic rf;
    if (rst_n) begin
      rf = mem_ce_n && !mem_oe_lo_n;
      if (!mem_ce_n && p_ce_n) begin
        n_ce_fall++;
        lat_a = mem_addr[7:0];
        ce_cnt = 0;
        if (first_fall < 0) first_fall = rel_cyc;
        if (hi_run < PRE) v_pre++;
        if (since_rf < FCE) v_fce++;
      end
      if (mem_ce_n && !p_ce_n && lo_run != ACC) v_ce++;
      if (rf && !p_rf) begin
        n_rf++;
        if (hi_run < RFD) v_rfd++;
        since_rf = 0;
      end
      if (!rf && p_rf && rf_run != FAP) v_fap++;
      if (mem_dq_oe && (mem_ce_n || (mem_we_lo_n && mem_we_hi_n))) v_dq++;
      if (!init_done && (!mem_we_lo_n || !mem_we_hi_n || !mem_oe_hi_n || ack)) v_init++;
      if (!mem_ce_n && (mem_oe_lo_n != mem_oe_hi_n)) v_oe++;
      if (!mem_ce_n && mem_dq_oe) begin
        if (!mem_we_lo_n) mem[lat_a][7:0]  = mem_dq_out[7:0];
        if (!mem_we_hi_n) mem[lat_a][15:8] = mem_dq_out[15:8];
      end
      if (init_done && falls_at_init < 0) begin
        falls_at_init = n_ce_fall;
        cyc_at_init = rel_cyc;
      end
      if (!mem_ce_n) begin ce_cnt++; lo_run++; hi_run = 0; end
      else begin lo_run = 0; hi_run++; end
      if (lo_run > CEMX) v_max++;
      rf_run = rf ? rf_run + 1 : 0;
      since_rf++;
      p_ce_n = mem_ce_n;
      p_rf = rf;
    end
  end

  // ---------------- host operation ----------------
  task automatic host_op(input logic w, input logic [14:0] a, input logic [15:0] d,
                         input logic [1:0] b, output logic [15:0] rd, output int lat);
    @(negedge clk);
    req = 1'b1; req_we = w; req_addr = a; req_wdata = d; req_be = b;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!ack && lat < 3000);
    rd = rdata;
    req = 1'b0;
  endtask

  task automatic wait_refresh();
    int n0 = n_rf;
    for (int i = 0; i < 4 * RINT && n_rf == n0; i++) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    // a write is requested already during reset and initialisation (R3)
    req = 1'b1; req_we = 1'b1; req_addr = 15'h0005; req_wdata = 16'h1234; req_be = 2'b11;
    repeat (3) @(negedge clk);
    chk("R1 strobes high in reset", {mem_ce_n, mem_oe_lo_n, mem_oe_hi_n, mem_we_lo_n, mem_we_hi_n}, 5'b11111);
    chk("R1 outputs low in reset", {mem_dq_oe, ack, init_done}, 3'b000);
    rst_n = 1'b1;
  endtask

  task automatic t_init();
    int lat = 0;
    logic [15:0] rd;
    while (!ack && lat < 2000) begin @(negedge clk); lat++; end
    req = 1'b0;
    chk("R3 held request acknowledged after init", {ack, init_done}, 2'b11);
    chk_ge("R2 first chip enable after power-up wait", first_fall, PWR, 100000);
    chk("R2 dummy pulses before init_done", 32'(falls_at_init), 32'(NDUM));
    chk_ge("R2 init_done time", cyc_at_init, PWR + NDUM * (ACC + PRE), PWR + NDUM * (ACC + PRE) + 2);
    host_op(1'b0, 15'h0005, 16'h0, 2'b11, rd, lat);
    chk("R3 write held during init stored", rd, 16'h1234);
  endtask

  task automatic t_rw();
    logic [15:0] rd;
    int lat;
    host_op(1'b1, 15'h0010, 16'hA5C3, 2'b11, rd, lat);
    host_op(1'b1, 15'h7F11, 16'h0F0F, 2'b11, rd, lat);
    host_op(1'b0, 15'h0010, 16'h0, 2'b11, rd, lat);
    chk("R4 read back word", rd, 16'hA5C3);
    host_op(1'b0, 15'h7F11, 16'h0, 2'b11, rd, lat);
    chk("R4 read back second word", rd, 16'h0F0F);
    host_op(1'b0, 15'h0033, 16'h0, 2'b11, rd, lat);
    chk("R4 read untouched word", rd, 16'h3333);
  endtask

  task automatic t_bytes();
    logic [15:0] rd;
    int lat;
    host_op(1'b1, 15'h0009, 16'hAAAA, 2'b11, rd, lat);
    host_op(1'b1, 15'h0009, 16'h1234, 2'b01, rd, lat);
    host_op(1'b0, 15'h0009, 16'h0, 2'b11, rd, lat);
    chk("R5 lower byte only", rd, 16'hAA34);
    host_op(1'b1, 15'h0009, 16'h5678, 2'b10, rd, lat);
    host_op(1'b0, 15'h0009, 16'h0, 2'b11, rd, lat);
    chk("R5 upper byte only", rd, 16'h5634);
    host_op(1'b1, 15'h0009, 16'hFFFF, 2'b00, rd, lat);
    host_op(1'b0, 15'h0009, 16'h0, 2'b11, rd, lat);
    chk("R5 no byte enabled keeps word", rd, 16'h5634);
  endtask

  task automatic t_latency();
    logic [15:0] rd;
    int lat;
    wait_refresh();
    repeat (12) @(negedge clk);
    host_op(1'b0, 15'h0010, 16'h0, 2'b11, rd, lat);
    chk("R8 idle latency", 32'(lat), 32'(ACC + 1));
    chk("R8 data with ack", rd, 16'hA5C3);
    @(negedge clk);
    chk("R8 ack single cycle", {31'b0, ack}, 32'd0);
  endtask

  task automatic t_collide();
    logic [15:0] rd;
    int lat;
    wait_refresh();
    host_op(1'b0, 15'h0010, 16'h0, 2'b11, rd, lat);
    chk_ge("R10 request waits for refresh", lat, ACC + 2, 40);
    chk("R10 data after refresh", rd, 16'hA5C3);
  endtask

  task automatic t_busy();
    logic [15:0] rd;
    int lat;
    int n0 = n_rf;
    int t0 = rel_cyc;
    int bad = 0;
    while (rel_cyc - t0 < 3 * RINT) begin
      host_op(1'b0, 15'h7F11, 16'h0, 2'b11, rd, lat);
      if (rd !== 16'h0F0F) bad++;
    end
    chk_ge("R10 refreshes under back-to-back requests", n_rf - n0, 2, 4);
    chk("R10 reads intact around refreshes", 32'(bad), 32'd0);
  endtask

  task automatic t_rate();
    int n0;
    repeat (20) @(negedge clk);
    n0 = n_rf;
    repeat (5 * RINT) @(negedge clk);
    chk_ge("R11 refresh count over five intervals", n_rf - n0, 4, 6);
  endtask

  task automatic t_timing();
    chk("R4 chip enable width", 32'(v_ce), 32'd0);
    chk("R4 both output enables together", 32'(v_oe), 32'd0);
    chk("R6 data drive window", 32'(v_dq), 32'd0);
    chk("R7 precharge", 32'(v_pre), 32'd0);
    chk("R9 refresh after chip enable", 32'(v_rfd), 32'd0);
    chk("R9 refresh width", 32'(v_fap), 32'd0);
    chk("R9 chip enable after refresh", 32'(v_fce), 32'd0);
    chk("R3 quiet during init", 32'(v_init), 32'd0);
    chk("R12 chip enable max low", 32'(v_max), 32'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_init();
    t_rw();
    t_bytes();
    t_latency();
    t_collide();
    t_busy();
    t_rate();
    t_timing();
    finish_run();
  end

endmodule